// File: doc/BRIEF.md
# Program Counter with Fixed Vectors

This block keeps the 21-bit byte address of the next instruction for a small Harvard-style core. Instructions are 16-bit words, so the address only ever holds even values. The address can move in four ways. It can step forward by one instruction. It can take a branch target. It can jump to one of two fixed interrupt entry points. It can return to address zero on reset. Only one change happens per clock, chosen by a fixed priority.

Software reaches the counter through the register file. The low byte of the counter can be read and written directly. Bits 15:8 and 20:16 are not directly accessible; they go through two holding latches. Writing the latches does not change the counter. A write to the low byte then loads all 21 bits in one clock, built from the two latches and the written byte. In the other direction, a read of the low byte copies the current bits 15:8 and 20:16 into the latches, where software can pick them up afterwards.

Top module: `pcv_top`

## Requirements
- R1: While `rst_n` is low, `pcValue` is 0x000000 and both latch outputs are 0.
- R2: With `advance` high and no higher-priority request, `pcValue` grows by 2 at the next edge, wrapping modulo 2^21. With no request at all, it holds its value.
- R3: With `branchLoad` high and no higher-priority request, `pcValue` takes `branchTarget` with bit 0 cleared at the next edge.
- R4: `irqHigh` high loads 0x000008 at the next edge. It overrides every other request except reset.
- R5: `irqLow` high with `irqHigh` low loads 0x000018 at the next edge. It overrides every request below it.
- R6: Priority of counter changes, from highest to lowest:
  - reset
  - `irqHigh`
  - `irqLow`
  - `regWrLow`
  - `branchLoad`
  - `advance`
- R7: `regRdData` always shows `pcValue[7:0]` in the same cycle.
- R8: `regWrHigh` stores `regWrData[7:0]` into the high latch. `regWrUpper` stores `regWrData[4:0]` into the upper latch. Neither write changes `pcValue`.
- R9: `regWrLow` (when no interrupt is requested) loads `pcValue` with {upper latch, high latch, `regWrData` with bit 0 cleared} at the next edge.
- R10: `regRdLow` copies `pcValue[15:8]` into the high latch and `pcValue[20:16]` into the upper latch at the next edge. It does not change `pcValue`. An explicit write to a latch in the same cycle wins over the copy for that latch.
- R11: `pcValue[0]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | Step to the next instruction |
| branchLoad | input | 1 | Load `branchTarget` |
| branchTarget | input | 21 | Branch destination byte address |
| irqHigh | input | 1 | High-priority interrupt request |
| irqLow | input | 1 | Low-priority interrupt request |
| regWrLow | input | 1 | Register write to the low counter byte |
| regWrHigh | input | 1 | Register write to the high latch |
| regWrUpper | input | 1 | Register write to the upper latch |
| regWrData | input | 8 | Register write data |
| regRdLow | input | 1 | Register read of the low byte (snapshot strobe) |
| regRdData | output | 8 | Low counter byte |
| latchHighOut | output | 8 | High holding latch |
| latchUpperOut | output | 5 | Upper holding latch |
| pcValue | output | 21 | Current program counter |

## Verification
Some properties are checked on every cycle by assertions:
- the counter stays word-aligned;
- at most one counter-change strobe is active at a time;
- each interrupt strobe produces its vector on the next edge;
- a step adds exactly two;
- each latch holds its value unless it is written or a snapshot is taken.

Other behaviour needs the bench's scenarios, because the result depends on earlier register traffic:
- the full order of priority between simultaneous requests;
- composing a full address from latches written in earlier cycles;
- the snapshot values;
- wrap-around at the top of the address space;
- a reset in the middle of a run.

// File: rtl/pcv_pkg.sv
package pcv_pkg;

  localparam int BYTE_W = 8;

  // One-cycle strobes from control to datapath and latch bank
  typedef struct packed {
    logic selVecHi;   // jump to high-priority vector
    logic selVecLo;   // jump to low-priority vector
    logic selCompose; // load {upper, high, low-byte write}
    logic selBranch;  // load branch target
    logic selStep;    // sequential advance
    logic wrHigh;     // write high latch
    logic wrUpper;    // write upper latch
    logic snapHigh;   // copy pc[15:8] into high latch
    logic snapUpper;  // copy pc[top:16] into upper latch
  } pcCtrl_t;

endpackage

// File: rtl/pcv_control.sv
module pcv_control
  import pcv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    advance,
  input  logic    branchLoad,
  input  logic    irqHigh,
  input  logic    irqLow,
  input  logic    regWrLow,
  input  logic    regWrHigh,
  input  logic    regWrUpper,
  input  logic    regRdLow,
  output pcCtrl_t ctrl
);

  logic anyIrq;
  logic takeCompose;
  logic takeBranch;

  always_comb begin
    anyIrq      = irqHigh | irqLow;
    takeCompose = regWrLow & ~anyIrq;
    takeBranch  = branchLoad & ~anyIrq & ~regWrLow;

    ctrl            = '0;
    ctrl.selVecHi   = irqHigh;
    ctrl.selVecLo   = irqLow & ~irqHigh;
    ctrl.selCompose = takeCompose;
    ctrl.selBranch  = takeBranch;
    ctrl.selStep    = advance & ~anyIrq & ~regWrLow & ~branchLoad;
    ctrl.wrHigh     = regWrHigh;
    ctrl.wrUpper    = regWrUpper;
    ctrl.snapHigh   = regRdLow & ~regWrHigh;
    ctrl.snapUpper  = regRdLow & ~regWrUpper;
  end

  // R6: at most one counter source chosen per cycle
  a_r6_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.selVecHi, ctrl.selVecLo, ctrl.selCompose,
              ctrl.selBranch, ctrl.selStep}));

  // R4: high-priority request always selects its vector
  a_r4_hi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irqHigh |-> (ctrl.selVecHi && !ctrl.selVecLo && !ctrl.selCompose));

  // R10: an explicit latch write suppresses the snapshot of that latch
  a_r10_write_over_snap: assert property (@(posedge clk) disable iff (!rst_n)
    regWrHigh |-> !ctrl.snapHigh);

endmodule

// File: rtl/pcv_latch_bank.sv
module pcv_latch_bank
  import pcv_pkg::*;
#(
  parameter int PC_W = 21
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  pcCtrl_t               ctrl,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic [PC_W-1:0]       pcValue,
  output logic [BYTE_W-1:0]     latchHigh,
  output logic [PC_W-2*BYTE_W-1:0] latchUpper
);

  localparam int UPPER_W = PC_W - 2*BYTE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latchHigh <= '0;
    end else if (ctrl.wrHigh) begin
      latchHigh <= wrData;
    end else if (ctrl.snapHigh) begin
      latchHigh <= pcValue[2*BYTE_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latchUpper <= '0;
    end else if (ctrl.wrUpper) begin
      latchUpper <= wrData[UPPER_W-1:0];
    end else if (ctrl.snapUpper) begin
      latchUpper <= pcValue[PC_W-1:2*BYTE_W];
    end
  end

  // R8/R10: latches only move on a write or a snapshot
  a_r8_high_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.wrHigh && !ctrl.snapHigh) |=> $stable(latchHigh));

  a_r8_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.wrUpper && !ctrl.snapUpper) |=> $stable(latchUpper));

  // R10: snapshot captures the counter bits seen in that cycle
  a_r10_snap_high: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.snapHigh |=> latchHigh == $past(pcValue[2*BYTE_W-1:BYTE_W]));

endmodule

// File: rtl/pcv_datapath.sv
module pcv_datapath
  import pcv_pkg::*;
#(
  parameter int              PC_W        = 21,
  parameter int              INSTR_BYTES = 2,
  parameter logic [PC_W-1:0] RESET_VEC   = '0,
  parameter logic [PC_W-1:0] HI_VEC      = PC_W'(8),
  parameter logic [PC_W-1:0] LO_VEC      = PC_W'(24)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pcCtrl_t         ctrl,
  input  logic [PC_W-1:0] branchTarget,
  input  logic [PC_W-1:0] composedTarget,
  output logic [PC_W-1:0] pcValue
);

  localparam logic [PC_W-1:0] STEP       = PC_W'(INSTR_BYTES);
  localparam logic [PC_W-1:0] ALIGN_MASK = ~(PC_W'(INSTR_BYTES - 1));

  logic [PC_W-1:0] pcNext;

  always_comb begin
    pcNext = pcValue;
    if (ctrl.selVecHi)        pcNext = HI_VEC;
    else if (ctrl.selVecLo)   pcNext = LO_VEC;
    else if (ctrl.selCompose) pcNext = composedTarget & ALIGN_MASK;
    else if (ctrl.selBranch)  pcNext = branchTarget & ALIGN_MASK;
    else if (ctrl.selStep)    pcNext = pcValue + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcValue <= RESET_VEC;
    else        pcValue <= pcNext;
  end

  // R11: word alignment
  a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pcValue[0] == 1'b0);

  // R1: first cycle after reset release shows the reset vector
  a_r1_reset_vec: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pcValue == RESET_VEC);

  // R4/R5: vectors land one edge after their strobe
  a_r4_hi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.selVecHi |=> pcValue == HI_VEC);

  a_r5_lo_vector: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.selVecLo |=> pcValue == LO_VEC);

  // R2: step adds one instruction, idle holds
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.selStep |=> pcValue == $past(pcValue) + STEP);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.selVecHi || ctrl.selVecLo || ctrl.selCompose ||
      ctrl.selBranch || ctrl.selStep) |=> $stable(pcValue));

endmodule

// File: rtl/pcv_top.sv
module pcv_top
  import pcv_pkg::*;
#(
  parameter int PC_W = 21
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        advance,
  input  logic                        branchLoad,
  input  logic [PC_W-1:0]             branchTarget,
  input  logic                        irqHigh,
  input  logic                        irqLow,
  input  logic                        regWrLow,
  input  logic                        regWrHigh,
  input  logic                        regWrUpper,
  input  logic [BYTE_W-1:0]           regWrData,
  input  logic                        regRdLow,
  output logic [BYTE_W-1:0]           regRdData,
  output logic [BYTE_W-1:0]           latchHighOut,
  output logic [PC_W-2*BYTE_W-1:0]    latchUpperOut,
  output logic [PC_W-1:0]             pcValue
);

  pcCtrl_t         ctrl;
  logic [PC_W-1:0] composedTarget;

  pcv_control control_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (advance),
    .branchLoad (branchLoad),
    .irqHigh    (irqHigh),
    .irqLow     (irqLow),
    .regWrLow   (regWrLow),
    .regWrHigh  (regWrHigh),
    .regWrUpper (regWrUpper),
    .regRdLow   (regRdLow),
    .ctrl       (ctrl)
  );

  pcv_latch_bank #(.PC_W(PC_W)) latches_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .wrData     (regWrData),
    .pcValue    (pcValue),
    .latchHigh  (latchHighOut),
    .latchUpper (latchUpperOut)
  );

  assign composedTarget = {latchUpperOut, latchHighOut, regWrData};
  assign regRdData      = pcValue[BYTE_W-1:0];

  pcv_datapath #(.PC_W(PC_W)) datapath_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrl           (ctrl),
    .branchTarget   (branchTarget),
    .composedTarget (composedTarget),
    .pcValue        (pcValue)
  );

endmodule

// File: tb/pcv_top_tb_top.sv
module pcv_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        advance = 1'b0, branchLoad = 1'b0, irqHigh = 1'b0, irqLow = 1'b0;
  logic [20:0] branchTarget = '0;
  logic        regWrLow = 1'b0, regWrHigh = 1'b0, regWrUpper = 1'b0, regRdLow = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData, latchHighOut;
  logic [4:0]  latchUpperOut;
  logic [20:0] pcValue;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pcv_top dut_i (
    .clk(clk), .rst_n(rst_n), .advance(advance), .branchLoad(branchLoad),
    .branchTarget(branchTarget), .irqHigh(irqHigh), .irqLow(irqLow),
    .regWrLow(regWrLow), .regWrHigh(regWrHigh), .regWrUpper(regWrUpper),
    .regWrData(regWrData), .regRdLow(regRdLow), .regRdData(regRdData),
    .latchHighOut(latchHighOut), .latchUpperOut(latchUpperOut), .pcValue(pcValue)
  );

  typedef struct packed {
    logic        adv;
    logic        br;
    logic        ih;
    logic        il;
    logic [20:0] tgt;
    logic [20:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 21'h000000, 21'h000002}, // R2 step
    '{1'b1, 1'b0, 1'b0, 1'b0, 21'h000000, 21'h000004}, // R2 step
    '{1'b0, 1'b1, 1'b0, 1'b0, 21'h01ABCD, 21'h01ABCC}, // R3 odd target aligned
    '{1'b1, 1'b0, 1'b0, 1'b0, 21'h000000, 21'h01ABCE}, // R2 step
    '{1'b1, 1'b0, 1'b0, 1'b1, 21'h000000, 21'h000018}, // R5 low irq over step
    '{1'b0, 1'b0, 1'b1, 1'b1, 21'h000000, 21'h000008}, // R4 high over low
    '{1'b1, 1'b1, 1'b0, 1'b0, 21'h000100, 21'h000100}, // R6 branch over step
    '{1'b0, 1'b0, 1'b0, 1'b0, 21'h000000, 21'h000100}, // R2 hold
    '{1'b0, 1'b1, 1'b0, 1'b0, 21'h1FFFFE, 21'h1FFFFE}, // R3 top address
    '{1'b1, 1'b0, 1'b0, 1'b0, 21'h000000, 21'h000000}, // R2 wrap
    '{1'b0, 1'b1, 1'b0, 1'b1, 21'h000444, 21'h000018}  // R5 low irq over branch
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    advance = 0; branchLoad = 0; irqHigh = 0; irqLow = 0; branchTarget = '0;
    regWrLow = 0; regWrHigh = 0; regWrUpper = 0; regRdLow = 0; regWrData = '0;
  endtask

  // drive at negedge, apply one posedge, sample shortly after
  task automatic tick();
    @(posedge clk);
    #1;
    idleInputs();
    @(negedge clk);
  endtask

  initial begin : watchdog
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idleInputs();
    #7;
    // R1 reset state
    check("R1 pc", {11'd0, pcValue}, 32'h0);
    check("R1 latchHigh", {24'd0, latchHighOut}, 32'h0);
    check("R1 latchUpper", {27'd0, latchUpperOut}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      advance = VECS[i].adv; branchLoad = VECS[i].br;
      irqHigh = VECS[i].ih;  irqLow = VECS[i].il;
      branchTarget = VECS[i].tgt;
      tick();
      check($sformatf("R2-R6 vector %0d", i), {11'd0, pcValue}, {11'd0, VECS[i].exp});
    end

    // R8: latch writes, counter untouched (pc is 0x18 here)
    regWrHigh = 1; regWrData = 8'h12; tick();
    regWrUpper = 1; regWrData = 8'hFF; tick();
    check("R8 latchHigh", {24'd0, latchHighOut}, 32'h12);
    check("R8 latchUpper", {27'd0, latchUpperOut}, 32'h1F);
    check("R8 pc unchanged", {11'd0, pcValue}, 32'h18);

    // R9 + R6: composed load wins over branch and step
    regWrLow = 1; regWrData = 8'h35; branchLoad = 1; branchTarget = 21'h000222; advance = 1;
    tick();
    check("R9 composed", {11'd0, pcValue}, 32'h1F1234);
    check("R7 rdData", {24'd0, regRdData}, 32'h34);

    // R10 snapshot
    branchLoad = 1; branchTarget = 21'h0A5670; tick();
    check("R7 rdData after branch", {24'd0, regRdData}, 32'h70);
    regRdLow = 1; tick();
    check("R10 snap high", {24'd0, latchHighOut}, 32'h56);
    check("R10 snap upper", {27'd0, latchUpperOut}, 32'h0A);
    check("R10 pc unchanged", {11'd0, pcValue}, 32'h0A5670);

    // R10: explicit write beats snapshot for that latch only
    regRdLow = 1; regWrHigh = 1; regWrData = 8'hC3; tick();
    check("R10 write wins high", {24'd0, latchHighOut}, 32'hC3);
    check("R10 upper still snapped", {27'd0, latchUpperOut}, 32'h0A);

    // R4 + R6: interrupt beats low-byte write
    regWrLow = 1; regWrData = 8'h40; irqHigh = 1; tick();
    check("R4 over compose", {11'd0, pcValue}, 32'h8);

    // R5: low irq beats low-byte write
    regWrLow = 1; regWrData = 8'h40; irqLow = 1; tick();
    check("R5 over compose", {11'd0, pcValue}, 32'h18);

    // R1: reset in mid-run
    rst_n = 0; #1;
    check("R1 async pc", {11'd0, pcValue}, 32'h0);
    check("R1 async latchHigh", {24'd0, latchHighOut}, 32'h0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    advance = 1; tick();
    check("R2 step after reset", {11'd0, pcValue}, 32'h2);
    check("R11 aligned", {31'd0, pcValue[0]}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule